// File: doc/BRIEF.md
# PHY Diagnostic Loopback Path Controller

This block sits in the digital datapath of a 10/100 Ethernet PHY, between the PCS symbol encoder and decoder and the line side. It selects where 5-bit code groups go. With no loopback selected, the transmit code groups go to the line encoder and the recovered line symbols go to the receive decoder. In near-end (local) loopback, the transmit code groups are also sent back into the receive decoder input, the transmit driver is disabled and signal detect is pinned high. In far-end (remote) loopback, the symbols recovered from the line are sent back into the line-encoding stage that feeds the driver, and signal detect is pinned low.

Two configuration bits choose the mode. In the surrounding register map they live in control register bit 14 (near-end) and mode-control register 21 bit 3 (far-end). The mode register samples them only on a symbol-advance strobe, so a change never splits a code group. Both symbol outputs pass through one register stage that also advances on the strobe. The signal-detect and driver-enable outputs depend on the registered mode, without registers of their own.

Top module: `phy_lpbk_ctrl`

## Requirements
- R1: After reset the mode is none and both symbol outputs hold the idle code 5'b11111. While in this mode, `sd_out` equals `sd_raw` and `tx_drv_en` is 1.
- R2: With neither enable set at a strobe edge, `rx_sym_out` takes `rx_sym_line` and `tx_sym_out` takes `tx_sym_in` at that edge, so each is visible one cycle after the strobe.
- R3: With `near_lb_en`=1 at a strobe edge, `rx_sym_out` takes `tx_sym_in` at that edge and `tx_sym_out` still takes `tx_sym_in`.
- R4: While near-end loopback is the active mode, `sd_out`=1 and `tx_drv_en`=0, whatever `sd_raw` is.
- R5: With `far_lb_en`=1 and `near_lb_en`=0 at a strobe edge, `tx_sym_out` takes `rx_sym_line` at that edge and `rx_sym_out` still takes `rx_sym_line`.
- R6: While far-end loopback is the active mode, `sd_out`=0 and `tx_drv_en`=1, whatever `sd_raw` is.
- R7: With both enables set at a strobe edge, near-end loopback is selected.
- R8: A change of the enables has no effect on `sd_out`, `tx_drv_en` or the routing until the next strobe edge.
- R9: With `sym_adv`=0, both symbol outputs hold their values whatever the symbol inputs do.
- R10: With no loopback active, `sd_out` follows `sd_raw` in the same cycle for both values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| near_lb_en | input | 1 | Near-end (local) loopback request |
| far_lb_en | input | 1 | Far-end (remote) loopback request |
| sym_adv | input | 1 | Symbol-advance strobe; the mode and the symbol outputs update only when it is high |
| tx_sym_in | input | 5 | Code group from the PCS encoder |
| rx_sym_line | input | 5 | Symbol recovered from the line |
| sd_raw | input | 1 | Output of the real signal detector |
| rx_sym_out | output | 5 | Code group presented to the PCS decoder |
| tx_sym_out | output | 5 | Symbol presented to the line encoder |
| sd_out | output | 1 | Signal detect after the mode override |
| tx_drv_en | output | 1 | Transmit driver enable (0 tri-states the driver) |

## Verification
The hardest case to reach is the window between an enable change and the next strobe. In that window the requested mode differs from the active one, and the outputs must still reflect the old mode. The bench opens this window on purpose. It enters each mode with a strobe, then changes the enables, the symbol inputs and `sd_raw` with the strobe held low. It confirms that the overrides and the held symbols still belong to the old mode before it issues the next strobe. It also sweeps every enable pair against both detector levels and several symbol patterns.

// File: rtl/lpbk_pkg.sv
`timescale 1ns/1ps
package lpbk_pkg;

  typedef enum logic [1:0] {
    LB_NONE = 2'd0,
    LB_NEAR = 2'd1,
    LB_FAR  = 2'd2
  } lb_mode_e;

  // Near-end request outranks far-end request.
  function automatic lb_mode_e pick_mode(input logic near_req, input logic far_req);
    if (near_req)     return LB_NEAR;
    else if (far_req) return LB_FAR;
    else              return LB_NONE;
  endfunction

  // Signal detect seen by the upper layers under each mode.
  function automatic logic sd_level(input lb_mode_e m, input logic raw);
    case (m)
      LB_NEAR: return 1'b1;
      LB_FAR:  return 1'b0;
      default: return raw;
    endcase
  endfunction

  // Driver is off only while looping locally.
  function automatic logic drv_level(input lb_mode_e m);
    return (m != LB_NEAR);
  endfunction

endpackage

// File: rtl/lpbk_mode_ctrl.sv
`timescale 1ns/1ps
module lpbk_mode_ctrl
  import lpbk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv,
  input  logic     near_req,
  input  logic     far_req,
  output lb_mode_e mode_nxt,
  output lb_mode_e mode_q
);

  assign mode_nxt = pick_mode(near_req, far_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mode_q <= LB_NONE;
    else if (adv) mode_q <= mode_nxt;
  end

  // R8: mode only moves on a symbol boundary
  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(mode_q));

  // R7: near-end wins when both are requested
  assert_near_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && near_req) |=> (mode_q == LB_NEAR));

endmodule

// File: rtl/lpbk_lane.sv
`timescale 1ns/1ps
module lpbk_lane #(
  parameter int          W        = 5,
  parameter logic [W-1:0] IDLE_SYM = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         take_alt,
  input  logic [W-1:0] main_sym,
  input  logic [W-1:0] alt_sym,
  output logic [W-1:0] q
);

  logic [W-1:0] pick;
  assign pick = take_alt ? alt_sym : main_sym;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= IDLE_SYM;
    else if (adv) q <= pick;
  end

  // R9: lane holds between strobes
  assert_lane_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(q));

endmodule

// File: rtl/lpbk_line_ovr.sv
`timescale 1ns/1ps
module lpbk_line_ovr
  import lpbk_pkg::*;
(
  input  lb_mode_e mode,
  input  logic     sd_raw,
  output logic     sd_out,
  output logic     drv_en
);

  always_comb begin
    sd_out = sd_level(mode, sd_raw);
    drv_en = drv_level(mode);
  end

endmodule

// File: rtl/phy_lpbk_ctrl.sv
`timescale 1ns/1ps
module phy_lpbk_ctrl
  import lpbk_pkg::*;
#(
  parameter int           SYM_W    = 5,
  parameter logic [SYM_W-1:0] IDLE_SYM = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             near_lb_en,
  input  logic             far_lb_en,
  input  logic             sym_adv,
  input  logic [SYM_W-1:0] tx_sym_in,
  input  logic [SYM_W-1:0] rx_sym_line,
  input  logic             sd_raw,
  output logic [SYM_W-1:0] rx_sym_out,
  output logic [SYM_W-1:0] tx_sym_out,
  output logic             sd_out,
  output logic             tx_drv_en
);

  localparam int NLANE    = 2;
  localparam int LANE_DEC = 0;   // toward the PCS decoder
  localparam int LANE_ENC = 1;   // toward the line encoder

  lb_mode_e mode_nxt, mode_q;

  // Named events for the assertions
  logic loop_near_evt, loop_far_evt;
  assign loop_near_evt = sym_adv && (mode_nxt == LB_NEAR);
  assign loop_far_evt  = sym_adv && (mode_nxt == LB_FAR);

  lpbk_mode_ctrl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (sym_adv),
    .near_req (near_lb_en),
    .far_req  (far_lb_en),
    .mode_nxt (mode_nxt),
    .mode_q   (mode_q)
  );

  logic [SYM_W-1:0] lane_main [NLANE];
  logic [SYM_W-1:0] lane_alt  [NLANE];
  logic [SYM_W-1:0] lane_q    [NLANE];
  logic             lane_sel  [NLANE];

  assign lane_main[LANE_DEC] = rx_sym_line;
  assign lane_alt [LANE_DEC] = tx_sym_in;
  assign lane_sel [LANE_DEC] = (mode_nxt == LB_NEAR);
  assign lane_main[LANE_ENC] = tx_sym_in;
  assign lane_alt [LANE_ENC] = rx_sym_line;
  assign lane_sel [LANE_ENC] = (mode_nxt == LB_FAR);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    lpbk_lane #(.W(SYM_W), .IDLE_SYM(IDLE_SYM)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (sym_adv),
      .take_alt (lane_sel[g]),
      .main_sym (lane_main[g]),
      .alt_sym  (lane_alt[g]),
      .q        (lane_q[g])
    );
  end

  assign rx_sym_out = lane_q[LANE_DEC];
  assign tx_sym_out = lane_q[LANE_ENC];

  lpbk_line_ovr u_ovr (
    .mode   (mode_q),
    .sd_raw (sd_raw),
    .sd_out (sd_out),
    .drv_en (tx_drv_en)
  );

  // R3: transmit code group returns to the decoder
  assert_near_loop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    loop_near_evt |=> (rx_sym_out == $past(tx_sym_in)));

  // R4: local mode pins detect high and silences the driver
  assert_near_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
    loop_near_evt |=> (sd_out && !tx_drv_en));

  // R5: line symbols return to the encoder
  assert_far_loop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_far_evt |=> (tx_sym_out == $past(rx_sym_line)));

  // R6: remote mode pins detect low, driver stays on
  assert_far_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
    loop_far_evt |=> (!sd_out && tx_drv_en));

  // R2: pass-through routing
  assert_normal_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_adv && !near_lb_en && !far_lb_en) |=>
      (rx_sym_out == $past(rx_sym_line)) && (tx_sym_out == $past(tx_sym_in)));

endmodule

// File: tb/sim_phy_lpbk_ctrl.sv
`timescale 1ns/1ps
module sim_phy_lpbk_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       near_lb_en, far_lb_en, sym_adv, sd_raw;
  logic [4:0] tx_sym_in, rx_sym_line;
  logic [4:0] rx_sym_out, tx_sym_out;
  logic       sd_out, tx_drv_en;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  phy_lpbk_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .near_lb_en(near_lb_en), .far_lb_en(far_lb_en),
    .sym_adv(sym_adv), .tx_sym_in(tx_sym_in), .rx_sym_line(rx_sym_line),
    .sd_raw(sd_raw), .rx_sym_out(rx_sym_out), .tx_sym_out(tx_sym_out),
    .sd_out(sd_out), .tx_drv_en(tx_drv_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Expected outputs from the requirements
  function automatic int exp_rx(input bit n, input bit f, input int t, input int r);
    return n ? t : r;
  endfunction
  function automatic int exp_tx(input bit n, input bit f, input int t, input int r);
    return (!n && f) ? r : t;
  endfunction
  function automatic int exp_sd(input bit n, input bit f, input bit raw);
    return n ? 1 : (f ? 0 : int'(raw));
  endfunction
  function automatic int exp_drv(input bit n);
    return n ? 0 : 1;
  endfunction

  // Present inputs with a strobe, check one cycle later (R2..R7, R10)
  task automatic step(input bit n, input bit f, input bit raw, input int t, input int r);
    @(negedge clk);
    near_lb_en = n; far_lb_en = f; sd_raw = raw;
    tx_sym_in = 5'(t); rx_sym_line = 5'(r); sym_adv = 1'b1;
    @(negedge clk);
    sym_adv = 1'b0;
    chk(n ? "R3 rx route" : (f ? "R5 rx route" : "R2 rx route"), int'(rx_sym_out), exp_rx(n, f, t, r));
    chk(n ? "R3 tx route" : (f ? "R5 tx route" : "R2 tx route"), int'(tx_sym_out), exp_tx(n, f, t, r));
    chk(n ? (f ? "R7 sd" : "R4 sd") : (f ? "R6 sd" : "R10 sd"), int'(sd_out), exp_sd(n, f, raw));
    chk(n ? (f ? "R7 drv" : "R4 drv") : "R6 drv", int'(tx_drv_en), exp_drv(n));
    sd_raw = ~raw;
    #0.5;
    chk(n ? "R4 sd flip" : (f ? "R6 sd flip" : "R10 sd flip"), int'(sd_out), exp_sd(n, f, ~raw));
  endtask

  // Change requests and data without a strobe (R8, R9)
  task automatic no_strobe(input bit n, input bit f, input bit n2, input bit f2);
    int hold_rx, hold_tx;
    step(n, f, 1'b1, 5'h0A, 5'h15);
    hold_rx = int'(rx_sym_out);
    hold_tx = int'(tx_sym_out);
    @(negedge clk);
    near_lb_en = n2; far_lb_en = f2;
    tx_sym_in = 5'h03; rx_sym_line = 5'h1C; sd_raw = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 rx hold", int'(rx_sym_out), hold_rx);
    chk("R9 tx hold", int'(tx_sym_out), hold_tx);
    chk("R8 sd old mode", int'(sd_out), exp_sd(n, f, 1'b1));
    chk("R8 drv old mode", int'(tx_drv_en), exp_drv(n));
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; near_lb_en = 1'b0; far_lb_en = 1'b0; sym_adv = 1'b0;
    sd_raw = 1'b0; tx_sym_in = '0; rx_sym_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rx idle", int'(rx_sym_out), 31);
    chk("R1 tx idle", int'(tx_sym_out), 31);
    chk("R1 sd follows", int'(sd_out), 0);
    chk("R1 drv on", int'(tx_drv_en), 1);
    sd_raw = 1'b1; #0.5;
    chk("R1 sd follows hi", int'(sd_out), 1);

    // Sweep every request pair, both detector levels, several symbols
    for (int e = 0; e < 4; e++)
      for (int raw = 0; raw < 2; raw++)
        for (int s = 0; s < 32; s += 5)
          step(e[0], e[1], raw[0], s, 31 - s);

    // Pending request window for every old/new pair
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        if (a != b) no_strobe(a[0], a[1], b[0], b[1]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule